// File: doc/BRIEF.md
# Supply Brown-Out Monitor Controller

This block is the digital side of a supply-voltage monitor. An analog comparator, outside the block, drives a signal that is high while the supply is below the falling trip level. Because of the comparator's hysteresis, that signal stays high until the supply climbs past the higher rising trip level. The block passes the signal through a synchronizer and keeps a low-voltage status bit. It raises an interrupt flag on every change of that status and drives two outputs: an interrupt request and a system reset request.

Software sees one control/status byte. Bit 7 is the read-only low-voltage status. Bit 6 is the read-only interrupt flag. Bit 5 is the interrupt enable, which can be read and written. Bit 4 is a write-only acknowledge. Two configuration inputs set the operating mode:

- One input powers the monitor down.
- The other disables the reset path. This leaves interrupt-only or polled operation.

While the reset path is enabled, a low supply causes a reset. The reset clears the interrupt enable and overrides the interrupt. It is held for a minimum number of cycles after the supply recovers.

Top module: `supply_guard`

## Requirements
- R1: The status byte reads bit 7 = synchronized comparator level. The flag (bit 6) is set whenever bit 7 changes, whether it rises or falls.
- R2: `irq` is 1 exactly when the flag and the interrupt enable (bit 5) are both 1, and no reset is active.
- R3: A write with bit 4 = 1 clears the flag, and a write with bit 4 = 0 leaves it unchanged. Bit 4 always reads 0. If a status change and an acknowledge land in the same cycle, the flag stays 1.
- R4: While `cfg_pwrdn` = 1, the status bit holds its value, the flag is not set, and no reset is issued.
- R5: While `cfg_rst_dis` = 1, a low status never asserts `sys_rst_req`.
- R6: With the monitor active and resets enabled, a low status asserts `sys_rst_req` and forces the interrupt enable to 0. Writes to bit 5 are ignored while the low condition lasts, and `irq` stays 0 while the reset is asserted.
- R7: `sys_rst_req` is held for as long as the status is low. It drops exactly HOLD_CYCLES cycles after the low condition ends.
- R8: After reset, the flag and the interrupt enable are 0, and the status equals the current synchronized input. The reset itself never causes the flag to set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_low | input | 1 | Asynchronous comparator output, 1 = supply low |
| cfg_pwrdn | input | 1 | 1 = monitor powered down |
| cfg_rst_dis | input | 1 | 1 = reset path disabled |
| wr_en | input | 1 | Write strobe for the status byte |
| wr_data | input | 8 | Write data (bit 5 enable, bit 4 acknowledge) |
| rd_data | output | 8 | Status byte {status, flag, enable, 5'b0} |
| irq | output | 1 | Interrupt request |
| sys_rst_req | output | 1 | System reset request |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same cycle as a status change. The comparator edge passes through three registers before it reaches the flag. The bench therefore changes `cmp_low` on a falling edge and counts two rising edges. It then presents the acknowledge write for the third edge and checks that the flag survives. The reset release is timed with the same edge counting: the bench checks that `sys_rst_req` is still high one cycle before the expected drop and low on the cycle it is due.

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_low,
  input  logic       cfg_pwrdn,
  input  logic       cfg_rst_dis,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       sys_rst_req
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic          cmp_s1, cmp_s2;
  logic          stat_q, flag_q, ie_q, rst_q;
  logic [CW-1:0] hold_cnt;
  logic          unused_bits;

  wire active   = ~cfg_pwrdn;
  wire toggle   = active & (cmp_s2 ^ stat_q);
  wire ack      = wr_en & wr_data[4];
  wire rst_cond = active & ~cfg_rst_dis & stat_q;

  assign unused_bits = ^{wr_data[7:6], wr_data[3:0]};

  always_ff @(posedge clk) begin
    cmp_s1 <= cmp_low;
    cmp_s2 <= cmp_s1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q   <= cmp_s2;
      flag_q   <= 1'b0;
      ie_q     <= 1'b0;
      rst_q    <= 1'b0;
      hold_cnt <= '0;
    end else begin
      if (active) stat_q <= cmp_s2;

      if (toggle)   flag_q <= 1'b1;
      else if (ack) flag_q <= 1'b0;

      if (rst_cond)   ie_q <= 1'b0;
      else if (wr_en) ie_q <= wr_data[5];

      if (rst_cond) begin
        rst_q    <= 1'b1;
        hold_cnt <= '0;
      end else if (rst_q) begin
        if (hold_cnt == CW'(HOLD_CYCLES - 1)) rst_q <= 1'b0;
        else hold_cnt <= hold_cnt + CW'(1);
      end
    end
  end

  assign rd_data     = {stat_q, flag_q, ie_q, 5'b0};
  assign irq         = flag_q & ie_q & ~rst_q;
  assign sys_rst_req = rst_q;
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmp_low,
  input logic       cfg_pwrdn,
  input logic       cfg_rst_dis,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       sys_rst_req
);
  // R1
  flag_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] != $past(rd_data[7])) |-> rd_data[6]);

  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4]) |=> (!rd_data[6] || (rd_data[7] != $past(rd_data[7]))));

  // R3
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4:0] == 5'b0);

  // R4
  pwrdn_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pwrdn |=> $stable(rd_data[7]));

  // R6
  rst_over_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> !irq);

  // R6
  rst_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !cfg_pwrdn && !cfg_rst_dis) |=> (sys_rst_req && !rd_data[5]));

  // R7
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_req) |-> !$past(rd_data[7] && !cfg_pwrdn && !cfg_rst_dis));

  // R2
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[6] && rd_data[5]));
endmodule

bind supply_guard supply_guard_chk u_chk (.*);

// File: tb/supply_guard_bench.sv
module supply_guard_bench;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_low = 1'b0;
  logic       cfg_pwrdn = 1'b0;
  logic       cfg_rst_dis = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq, sys_rst_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  supply_guard #(.HOLD_CYCLES(HOLD)) u_supply_guard (
    .clk(clk), .rst_n(rst_n), .cmp_low(cmp_low), .cfg_pwrdn(cfg_pwrdn),
    .cfg_rst_dis(cfg_rst_dis), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .sys_rst_req(sys_rst_req));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(posedge clk);
    #1 wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset_state();
    cmp_low = 1'b0;
    do_reset();
    chk("R8", "rd after reset low", rd_data, 8'h00);
    chk("R8", "irq after reset", irq, 0);
    chk("R8", "rst after reset", sys_rst_req, 0);
    cmp_low = 1'b1;
    cyc(3);
    do_reset();
    cyc(4);
    chk("R8", "rd after reset high input", rd_data, 8'h80);
    cmp_low = 1'b0;
    cyc(5);
    wr(8'h10);
    chk("R3", "flag cleared", rd_data, 8'h00);
  endtask

  task automatic t_toggle();
    cmp_low = 1'b1;
    cyc(5);
    chk("R1", "rise sets flag", rd_data, 8'hC0);
    chk("R2", "irq without enable", irq, 0);
    chk("R5", "no reset when disabled", sys_rst_req, 0);
    wr(8'h20);
    chk("R2", "irq with enable", irq, 1);
    wr(8'h30);
    chk("R3", "ack clears flag", rd_data, 8'hA0);
    chk("R2", "irq after ack", irq, 0);
    cmp_low = 1'b0;
    cyc(5);
    chk("R1", "fall sets flag", rd_data, 8'h60);
    chk("R2", "irq on fall", irq, 1);
    wr(8'h20);
    chk("R3", "ack 0 no effect", rd_data, 8'h60);
    wr(8'h30);
    chk("R3", "ack clears again", rd_data, 8'h20);
  endtask

  task automatic t_collision();
    @(negedge clk);
    cmp_low = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 8'h30;
    @(posedge clk);
    #1 wr_en = 1'b0;
    cyc(2);
    chk("R3", "set wins over ack", rd_data, 8'hE0);
    wr(8'h30);
    chk("R3", "later ack", rd_data, 8'hA0);
    cmp_low = 1'b0;
    cyc(5);
    wr(8'h10);
    chk("R3", "clean state", rd_data, 8'h00);
  endtask

  task automatic t_pwrdn();
    cfg_pwrdn = 1'b1;
    cfg_rst_dis = 1'b0;
    cyc(2);
    cmp_low = 1'b1;
    cyc(8);
    chk("R4", "status frozen, no flag", rd_data, 8'h00);
    chk("R4", "no reset in power-down", sys_rst_req, 0);
    cmp_low = 1'b0;
    cyc(5);
    cfg_pwrdn = 1'b0;
    cyc(5);
    chk("R4", "clean after power-up", rd_data, 8'h00);
  endtask

  task automatic t_reset_path();
    cfg_rst_dis = 1'b0;
    wr(8'h20);
    cmp_low = 1'b1;
    cyc(5);
    chk("R6", "reset asserted", sys_rst_req, 1);
    chk("R6", "enable cleared", rd_data, 8'hC0);
    chk("R6", "irq suppressed", irq, 0);
    wr(8'h20);
    chk("R6", "enable write ignored", rd_data[5], 0);
    cyc(20);
    chk("R7", "held while low", sys_rst_req, 1);
    @(negedge clk);
    cmp_low = 1'b0;
    cyc(2 + HOLD);
    chk("R7", "still held before drop", sys_rst_req, 1);
    cyc(1);
    chk("R7", "released after hold", sys_rst_req, 0);
    chk("R1", "flag after recovery", rd_data, 8'h40);
    wr(8'h10);
    cfg_rst_dis = 1'b1;
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_toggle();
    t_collision();
    t_pwrdn();
    t_reset_path();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule